// File: doc/BRIEF.md
# External Interrupt Controller with Per-Line Trigger Select

This block gathers 32 external, asynchronous request lines and turns them into processor interrupts. Each line first crosses into the local clock domain through a two-flop synchroniser. A trigger selector then decides what sets that line's pending flag: a low level, a high level, a falling edge, a rising edge, or either edge. A per-line mask gates the pending flag onto the outputs. Lines 0 to 15 each drive their own interrupt output. Lines 16 to 31 are merged into a single shared output.

Software configures the block through a plain 32-bit register port. The registers are organised in groups of eight lines, and each group has a trigger-select word, a mask word and a pending word. A pending flag is cleared by writing a 1 to its bit. A pending flag also records requests while its line is masked, so the request is not lost and appears on the output as soon as the line is unmasked.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is high and right after it, every trigger-select field reads 0, every mask word reads 0xFF, every pending word reads 0, and all interrupt outputs are low.
- R2: Register word address = {bank[1:0], group[1:0]}. Bank 0 holds trigger select, bank 1 holds mask, bank 2 holds pending, and bank 3 reads 0 and ignores writes. Line n belongs to group n/8. Its trigger code sits in bits [4*(n%8)+2 : 4*(n%8)] of the group's select word, and bit 4*(n%8)+3 always reads 0. Its mask and pending bits sit at bit n%8, and bits 31:8 of the mask and pending words read 0.
- R3: Trigger code 0 (active low) and code 1 (active high) set the pending flag in every cycle in which the synchronised input is at the active level. A clear issued while the level is still active leaves the flag set. Once set, the flag holds after the level goes away, until it is cleared.
- R4: Code 2 sets the pending flag on a synchronised falling edge only. Code 3 sets it on a rising edge only. Code 4 sets it on either edge.
- R5: Codes 5, 6 and 7 never set the pending flag, whatever the input does.
- R6: A register write to bank 2 clears each pending flag whose data bit is 1. Bits written as 0 leave their flags unchanged. A set condition in the same cycle as a clear wins, and the flag stays 1.
- R7: An input change first shows in the pending register, and in the outputs, after the third rising clock edge that follows it. After only two edges, it does not show.
- R8: The pending flag is set whether the line is masked or not. A mask bit of 1 holds the line's output contribution low. Clearing the mask bit of a pending line raises its output.
- R9: For each line n from 0 to 15, irq_line[n] is high exactly when line n is pending and unmasked. Lines 16 to 31 never affect irq_line.
- R10: irq_shared is high exactly when at least one of lines 16 to 31 is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 32 | Asynchronous external request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address {bank, group} |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_line | output | 16 | Dedicated interrupts for lines 0 to 15 |
| irq_shared | output | 1 | Merged interrupt for lines 16 to 31 |

## Verification
The two functions that can land in the same cycle are a software write-1 clear of a pending flag and a fresh hardware set of that flag, from an edge or from a level that is still active. The bench provokes the collision on purpose. It raises an input, waits the two synchroniser edges, and then places the clear write so that it is sampled on the same clock edge that registers the detection. It then judges the result by reading the pending word back, where the flag must still be 1. Random phases produce further collisions with random inputs and random writes, and a bench-side reference model that applies set-over-clear priority checks every cycle.

// File: rtl/exi_pkg.sv
package exi_pkg;

    localparam int GRP_LINES    = 8;
    localparam int FIELD_W      = 3;
    localparam int FIELD_STRIDE = 4;
    localparam int BANK_W       = 2;

    typedef enum logic [FIELD_W-1:0] {
        TRIG_LVL_LO = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_FALL   = 3'd2,
        TRIG_RISE   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    typedef enum logic [BANK_W-1:0] {
        BANK_TYPE = 2'd0,
        BANK_MASK = 2'd1,
        BANK_PEND = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;

    typedef struct packed {
        logic now;
        logic prev;
    } samp_t;

    function automatic logic trig_hit(logic [FIELD_W-1:0] code, samp_t s);
        logic hit;
        case (code)
            TRIG_LVL_LO: hit = !s.now;
            TRIG_LVL_HI: hit = s.now;
            TRIG_FALL:   hit = s.prev && !s.now;
            TRIG_RISE:   hit = !s.prev && s.now;
            TRIG_BOTH:   hit = s.prev ^ s.now;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/exi_sync.sv
module exi_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[k] <= '0;
                    else     stage_q[k] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[k] <= '0;
                    else     stage_q[k] <= stage_q[k-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

    // R7: the last stage carries the previous stage one cycle later
    p_sync_chain_r7: assert property (@(posedge clk) disable iff (rst)
        stage_q[STAGES-1] == $past(stage_q[STAGES-2]));

endmodule

// File: rtl/exi_detect.sv
module exi_detect
    import exi_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NLINES-1:0]              sync_in,
    input  logic [NLINES-1:0][FIELD_W-1:0] type_vec,
    output logic [NLINES-1:0]              set_vec
);
    logic [NLINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sync_in;
    end

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            samp_t smp;
            assign smp.now  = sync_in[i];
            assign smp.prev = prev_q[i];
            assign set_vec[i] = trig_hit(type_vec[i], smp);

            // R5: reserved trigger codes never request
            p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (rst)
                (type_vec[i] > FIELD_W'(TRIG_BOTH)) |-> !set_vec[i]);
        end
    endgenerate

endmodule

// File: rtl/exi_regfile.sv
module exi_regfile
    import exi_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [BANK_W+$clog2(NLINES/GRP_LINES)-1:0] addr,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata,
    input  logic [NLINES-1:0]              set_vec,
    output logic [NLINES-1:0][FIELD_W-1:0] type_vec,
    output logic [NLINES-1:0]              mask_vec,
    output logic [NLINES-1:0]              pend_vec
);
    localparam int NGRP  = NLINES / GRP_LINES;
    localparam int GRP_W = $clog2(NGRP);
    localparam int ADR_W = BANK_W + GRP_W;

    bank_e            bank;
    logic [GRP_W-1:0] grp;

    assign bank = bank_e'(addr[ADR_W-1 -: BANK_W]);
    assign grp  = addr[GRP_W-1:0];

    logic [NLINES-1:0][FIELD_W-1:0] type_q;
    logic [NLINES-1:0]              mask_q;
    logic [NLINES-1:0]              pend_q;

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            localparam int G = i / GRP_LINES;
            localparam int B = i % GRP_LINES;
            logic hit_grp;
            logic clr;

            assign hit_grp = wr_en && (grp == GRP_W'(G));
            assign clr     = hit_grp && (bank == BANK_PEND) && wdata[B];

            always_ff @(posedge clk) begin
                if (rst) begin
                    type_q[i] <= '0;
                    mask_q[i] <= 1'b1;
                    pend_q[i] <= 1'b0;
                end else begin
                    if (hit_grp && bank == BANK_TYPE)
                        type_q[i] <= wdata[FIELD_STRIDE*B +: FIELD_W];
                    if (hit_grp && bank == BANK_MASK)
                        mask_q[i] <= wdata[B];
                    pend_q[i] <= set_vec[i] | (pend_q[i] & ~clr);
                end
            end

            // R3 R4: a request is always recorded
            p_set_records_r3: assert property (@(posedge clk) disable iff (rst)
                set_vec[i] |=> pend_q[i]);
            // R6: a clear without a competing request empties the flag
            p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
                (clr && !set_vec[i]) |=> !pend_q[i]);
            // R6: no clear, no loss
            p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (pend_q[i] && !clr) |=> pend_q[i]);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (grp == GRP_W'(i / GRP_LINES)) begin
                case (bank)
                    BANK_TYPE: rdata[FIELD_STRIDE*(i%GRP_LINES) +: FIELD_W] = type_q[i];
                    BANK_MASK: rdata[i%GRP_LINES] = mask_q[i];
                    BANK_PEND: rdata[i%GRP_LINES] = pend_q[i];
                    default:   ;
                endcase
            end
        end
    end

    assign type_vec = type_q;
    assign mask_vec = mask_q;
    assign pend_vec = pend_q;

endmodule

// File: rtl/exi_irq_out.sv
module exi_irq_out #(
    parameter int NLINES  = 32,
    parameter int NDIRECT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NLINES-1:0]  pend_vec,
    input  logic [NLINES-1:0]  mask_vec,
    output logic [NDIRECT-1:0] irq_line,
    output logic               irq_shared
);
    localparam int NSHARED = NLINES - NDIRECT;

    logic [NLINES-1:0] live;
    assign live = pend_vec & ~mask_vec;

    generate
        for (genvar i = 0; i < NDIRECT; i++) begin : g_direct
            assign irq_line[i] = live[i];
            // R8: a masked line stays silent
            p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
                mask_vec[i] |-> !irq_line[i]);
            // R9: a dedicated output implies its line is pending
            p_direct_src_r9: assert property (@(posedge clk) disable iff (rst)
                irq_line[i] |-> pend_vec[i]);
        end
    endgenerate

    assign irq_shared = |live[NLINES-1:NDIRECT];

    // R10: shared output needs a pending, unmasked line in the upper set
    p_shared_src_r10: assert property (@(posedge clk) disable iff (rst)
        irq_shared |-> ($countones(pend_vec[NLINES-1:NDIRECT] & ~mask_vec[NLINES-1:NDIRECT]) > 0));

    p_shared_width_r10: assert final (NSHARED > 0);

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import exi_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_DIRECT = 16,
    parameter int SYNC_DEPTH = 2,
    localparam int ADDR_W    = BANK_W + $clog2(NUM_LINES / GRP_LINES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LINES-1:0]  ext_in,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [NUM_DIRECT-1:0] irq_line,
    output logic                  irq_shared
);
    logic [NUM_LINES-1:0]              sync_vec;
    logic [NUM_LINES-1:0]              set_vec;
    logic [NUM_LINES-1:0][FIELD_W-1:0] type_vec;
    logic [NUM_LINES-1:0]              mask_vec;
    logic [NUM_LINES-1:0]              pend_vec;

    exi_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk), .rst (rst), .din (ext_in), .dout (sync_vec)
    );

    exi_detect #(.NLINES(NUM_LINES)) u_detect (
        .clk (clk), .rst (rst), .sync_in (sync_vec),
        .type_vec (type_vec), .set_vec (set_vec)
    );

    exi_regfile #(.NLINES(NUM_LINES)) u_regs (
        .clk (clk), .rst (rst), .wr_en (bus_wr), .addr (bus_addr),
        .wdata (bus_wdata), .rdata (bus_rdata), .set_vec (set_vec),
        .type_vec (type_vec), .mask_vec (mask_vec), .pend_vec (pend_vec)
    );

    exi_irq_out #(.NLINES(NUM_LINES), .NDIRECT(NUM_DIRECT)) u_out (
        .clk (clk), .rst (rst), .pend_vec (pend_vec), .mask_vec (mask_vec),
        .irq_line (irq_line), .irq_shared (irq_shared)
    );

    // R1: nothing is pending in the first cycle after reset
    p_reset_clean_r1: assert property (@(posedge clk)
        $fell(rst) |-> (pend_vec == '0 && irq_line == '0 && !irq_shared));

endmodule

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ext_in = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_line;
    logic        irq_shared;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ext_irq_ctrl u0 (
        .clk (clk), .rst (rst), .ext_in (ext_in), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq_line (irq_line), .irq_shared (irq_shared)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_s1, m_s2, m_prev, m_mask, m_pend;
    logic [2:0]  m_type [32];

    function automatic bit ref_hit(bit [2:0] c, bit now, bit prev);
        case (c)
            3'd0: return !now;
            3'd1: return now;
            3'd2: return prev && !now;
            3'd3: return !prev && now;
            3'd4: return now != prev;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_mask <= '1; m_pend <= '0;
            for (int i = 0; i < 32; i++) m_type[i] <= 3'd0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                bit st, cl;
                st = ref_hit(m_type[i], m_s2[i], m_prev[i]);
                cl = bus_wr && bus_addr == {2'd2, 2'(i/8)} && bus_wdata[i%8];
                m_pend[i] <= st | (m_pend[i] & ~cl);
                if (bus_wr && bus_addr == {2'd0, 2'(i/8)}) m_type[i] <= bus_wdata[4*(i%8) +: 3];
                if (bus_wr && bus_addr == {2'd1, 2'(i/8)}) m_mask[i] <= bus_wdata[i%8];
            end
            m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= ext_in;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd4711));

        // R1: reset state
        step(3);
        rd(4'h0, v); check("R1 type0", v, 32'h0);
        rd(4'h5, v); check("R1 mask1", v, 32'hFF);
        rd(4'h8, v); check("R1 pend0", v, 32'h0);
        check("R1 outputs", {15'd0, irq_shared, irq_line}, 32'h0);
        rst = 1'b0;

        for (int g = 0; g < 4; g++) wr(4'(g), 32'h55555555);
        step(4);
        for (int g = 0; g < 4; g++) wr(4'(8 + g), 32'hFF);
        rd(4'h8, v); check("R5 idle pend0", v, 32'h0);

        // R3/R7: level high on line 2
        wr(4'h0, 32'h55555155);
        ext_in[2] = 1'b1;
        step(2); rd(4'h8, v); check("R7 not yet after two edges", v, 32'h0);
        step(1); rd(4'h8, v); check("R7 R3 level high pending", v, 32'h04);
        check("R8 masked line quiet", {16'd0, irq_line}, 32'h0);
        wr(4'h8, 32'h04); rd(4'h8, v); check("R3 clear while active re-sets", v, 32'h04);
        ext_in[2] = 1'b0;
        step(3); rd(4'h8, v); check("R3 flag holds after level drops", v, 32'h04);
        wr(4'h8, 32'h04); rd(4'h8, v); check("R6 clear", v, 32'h0);

        // R3: level low on line 5
        wr(4'h0, 32'h55055555);
        step(2); rd(4'h8, v); check("R3 level low pending", v, 32'h20);
        ext_in[5] = 1'b1; step(3);
        wr(4'h8, 32'h20); rd(4'h8, v); check("R3 level low cleared once high", v, 32'h0);

        // R4/R9: rising on line 8, unmasked
        wr(4'h1, 32'h55555553); wr(4'h5, 32'hFE);
        ext_in[8] = 1'b1; step(1); ext_in[8] = 1'b0; step(2);
        check("R4 R9 rising drives irq_line[8]", {16'd0, irq_line}, 32'h100);
        wr(4'h9, 32'h01); step(3);
        rd(4'h9, v); check("R4 falling ignored by rising type", v, 32'h0);
        check("R9 irq_line low after clear", {16'd0, irq_line}, 32'h0);

        // R4: falling on line 9
        wr(4'h1, 32'h55555523);
        ext_in[9] = 1'b1; step(4); rd(4'h9, v); check("R4 rise ignored by falling type", v, 32'h0);
        ext_in[9] = 1'b0; step(3); rd(4'h9, v); check("R4 falling sets", v, 32'h02);
        wr(4'h9, 32'hFD); rd(4'h9, v); check("R6 zero bit keeps flag", v, 32'h02);
        wr(4'h9, 32'h02);

        // R4: both edges on line 10
        wr(4'h1, 32'h55555423);
        ext_in[10] = 1'b1; step(3); rd(4'h9, v); check("R4 both: rise", v, 32'h04);
        wr(4'h9, 32'h04);
        ext_in[10] = 1'b0; step(3); rd(4'h9, v); check("R4 both: fall", v, 32'h04);
        wr(4'h9, 32'h04);

        // R5: reserved codes on line 11 (6) and line 13 (7)
        wr(4'h1, 32'h55756423);
        ext_in[11] = 1'b1; ext_in[13] = 1'b1; step(4);
        ext_in[11] = 1'b0; ext_in[13] = 1'b0; step(4);
        rd(4'h9, v); check("R5 reserved codes never pend", v, 32'h0);

        // R6: clear coinciding with a new rising edge on line 12
        wr(4'h1, 32'h55736423);
        ext_in[12] = 1'b1; step(2);
        bus_wr = 1'b1; bus_addr = 4'h9; bus_wdata = 32'h10;
        @(negedge clk); bus_wr = 1'b0;
        rd(4'h9, v); check("R6 set beats coincident clear", v, 32'h10);
        wr(4'h9, 32'h10); rd(4'h9, v); check("R6 later clear", v, 32'h0);

        // R2: field layout and unused bits
        wr(4'h3, 32'hFFFFFFFF); rd(4'h3, v); check("R2 stride bits read zero", v, 32'h77777777);
        wr(4'h7, 32'hFFFFFF00); rd(4'h7, v); check("R2 mask upper bits", v, 32'h0);
        wr(4'hC, 32'hFFFFFFFF); rd(4'hC, v); check("R2 bank3 reads zero", v, 32'h0);
        wr(4'h7, 32'hFF);

        // R10/R8: shared group, lines 20 and 30
        wr(4'h2, 32'h55535555); wr(4'h3, 32'h53555555); wr(4'h6, 32'hEF);
        ext_in[30] = 1'b1; step(3);
        check("R8 masked shared line quiet", {31'd0, irq_shared}, 32'h0);
        rd(4'hB, v); check("R8 masked line still pends", v, 32'h40);
        wr(4'h7, 32'hBF);
        check("R10 unmask raises shared", {31'd0, irq_shared}, 32'h1);
        ext_in[20] = 1'b1; step(3);
        wr(4'hB, 32'h40);
        check("R10 shared held by line 20", {31'd0, irq_shared}, 32'h1);
        check("R9 shared lines leave irq_line", {16'd0, irq_line}, 32'h0);
        wr(4'hA, 32'h10);
        check("R10 shared drops", {31'd0, irq_shared}, 32'h0);

        // random phase against the model
        for (int c = 0; c < 3000; c++) begin
            logic [32:0] exp_o;
            exp_o = {|(m_pend[31:16] & ~m_mask[31:16]), m_pend[15:0] & ~m_mask[15:0]};
            check("R9 R10 random outputs", {15'd0, irq_shared, irq_line}, {15'd0, exp_o[16:0]});
            if (c % 8 == 0 && !bus_wr) begin
                logic [1:0] g;
                g = 2'($urandom_range(0, 3));
                rd({2'd2, g}, v);
                check("R6 random pending", v, {24'd0, m_pend[8*g +: 8]});
            end
            ext_in = ext_in ^ ($urandom & $urandom & $urandom);
            if ($urandom_range(0, 3) == 0) begin
                bus_wr = 1'b1; bus_addr = 4'($urandom); bus_wdata = $urandom;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule